// File: doc/BRIEF.md
# In-Place Memory Bubble Sort Sequencer

This block sorts the contents of a small single-port synchronous memory into ascending order where they sit, so that the smallest word ends up at address 0. It owns the memory's address, write-data, write-enable and read-enable lines while it runs, and it takes read data back from the memory one cycle after each read request.

The sequencer makes repeated passes over the memory. Each pass walks the adjacent address pairs from the bottom up. A magnitude comparator checks the word held in a first register against the next word as it arrives from the memory. When the held word is strictly larger, both words are captured in a two-register chain: the newer word goes into the first register and the older word moves into the second. Both are then written back to the opposite addresses, and a swap flag is set. The flag is tested and cleared when a pass finishes. If a full pass makes no swap, the sort is complete.

A one-cycle `start` pulse launches a sort while the block is idle. `busy` covers the whole run. `done` marks its last cycle.

Top module: `mem_bubble_sorter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `done`, `mem_we` and `mem_re` are all 0.
- R2: When `done` pulses, memory holds the initial words as a permutation in ascending order, with the smallest at address 0.
- R3: Words are exchanged only when the lower-addressed word is strictly greater than the next one. An all-equal or already-ascending memory is never written.
- R4: A pass with no swap ends the sort. An already-ascending memory finishes after exactly one pass.
- R5: `mem_we` and `mem_re` are never high in the same cycle. Each write lasts one cycle, and two back-to-back writes never target the same address.
- R6: A swap of pair (i, i+1) consists of two consecutive write cycles. The first writes the smaller word to address i. The second writes the larger word to address i+1. Swaps within one pass occur in ascending order of i.
- R7: `done` is high for exactly one cycle. `busy` is also high in that cycle, and `busy` is low in the following cycle.
- R8: A `start` pulse seen while `busy` is high has no effect on the writes, the result or the run length.
- R9: `busy` is high for 18 cycles per pass, plus 3 cycles for each swap at pairs 0 to 13, plus 2 cycles for a swap at pair 14. It rises in the cycle after `start` is sampled.
- R10: Read data is taken from `mem_rdata` in the cycle after `mem_re` is asserted with an address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a sort when idle |
| busy | output | 1 | High while a sort runs |
| done | output | 1 | One-cycle pulse in the final busy cycle |
| mem_addr | output | 4 | Memory address |
| mem_wdata | output | 4 | Memory write data |
| mem_rdata | input | 4 | Memory read data, valid one cycle after a read request |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |

## Verification
Each write is due in a predictable cycle. A reference sort runs over the same initial words and builds an ordered list of expected (address, data) writes, and the bench compares every cycle with `mem_we` high against the head of that list at the falling edge. `done` is due a fixed number of cycles after `start`, given by the R9 formula applied to the same model's swap positions. The bench counts `busy` cycles between falling edges and compares the count when `done` appears. The cycle after `done` is checked for `busy` low. The final memory contents are compared two cycles later, once the last write has landed.

// File: rtl/sort_pkg.sv
package sort_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FIRST,
        ST_CMP,
        ST_WR_LO,
        ST_WR_HI,
        ST_RESUME,
        ST_CHECK
    } sort_state_t;

    // Per-cycle datapath controls from the sequencer
    typedef struct packed {
        logic rd;        // read request
        logic wr;        // write request
        logic wsel_hi;   // write second register instead of first
        logic ld_first;  // first <= bus
        logic shift;     // first <= bus, second <= first
        logic restore;   // first <= second
    } sort_ctl_t;

    localparam sort_ctl_t CTL_NONE = '{default: 1'b0};

    function automatic logic is_busy_state(sort_state_t s);
        return s != ST_IDLE;
    endfunction

endpackage

// File: rtl/sort_mag_cmp.sv
module sort_mag_cmp #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         a_gt_b
);
    logic [W:0] gt_c;
    logic [W:0] eq_c;

    assign gt_c[W] = 1'b0;
    assign eq_c[W] = 1'b1;

    // MSB-first ripple: the first differing bit decides
    for (genvar k = W - 1; k >= 0; k--) begin : g_bit
        assign gt_c[k] = gt_c[k+1] | (eq_c[k+1] & a[k] & ~b[k]);
        assign eq_c[k] = eq_c[k+1] & ~(a[k] ^ b[k]);
    end

    assign a_gt_b = gt_c[0];
endmodule

// File: rtl/sort_hold_pair.sv
module sort_hold_pair #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bus_in,
    input  logic         ld_first,
    input  logic         shift,
    input  logic         restore,
    output logic [W-1:0] first_q,
    output logic [W-1:0] second_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            first_q  <= '0;
            second_q <= '0;
        end else if (shift) begin
            first_q  <= bus_in;
            second_q <= first_q;
        end else if (restore) begin
            first_q  <= second_q;
        end else if (ld_first) begin
            first_q  <= bus_in;
        end
    end
endmodule

// File: rtl/sort_ctrl.sv
module sort_ctrl
    import sort_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LAST   = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              gt,
    output sort_ctl_t         ctl,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done
);
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(LAST);

    sort_state_t       state, state_n;
    logic [ADDR_W-1:0] idx, idx_n;
    logic              flag, flag_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            flag  <= 1'b0;
        end else begin
            state <= state_n;
            idx   <= idx_n;
            flag  <= flag_n;
        end
    end

    always_comb begin
        state_n = state;
        idx_n   = idx;
        flag_n  = flag;
        ctl     = CTL_NONE;
        addr    = idx;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_n = ST_FETCH;
                    idx_n   = '0;
                    flag_n  = 1'b0;
                end
            end
            ST_FETCH: begin
                ctl.rd  = 1'b1;
                addr    = idx;
                state_n = ST_FIRST;
            end
            ST_FIRST: begin
                ctl.rd       = 1'b1;
                ctl.ld_first = 1'b1;
                addr         = idx + ADDR_W'(1);
                state_n      = ST_CMP;
            end
            ST_CMP: begin
                if (gt) begin
                    ctl.shift = 1'b1;
                    state_n   = ST_WR_LO;
                end else begin
                    ctl.ld_first = 1'b1;
                    if (idx == LAST_IDX) begin
                        state_n = ST_CHECK;
                    end else begin
                        ctl.rd = 1'b1;
                        addr   = idx + ADDR_W'(2);
                        idx_n  = idx + ADDR_W'(1);
                    end
                end
            end
            ST_WR_LO: begin
                ctl.wr  = 1'b1;
                addr    = idx;
                state_n = ST_WR_HI;
            end
            ST_WR_HI: begin
                ctl.wr      = 1'b1;
                ctl.wsel_hi = 1'b1;
                addr        = idx + ADDR_W'(1);
                flag_n      = 1'b1;
                if (idx == LAST_IDX) begin
                    state_n = ST_CHECK;
                end else begin
                    idx_n   = idx + ADDR_W'(1);
                    state_n = ST_RESUME;
                end
            end
            ST_RESUME: begin
                ctl.rd      = 1'b1;
                ctl.restore = 1'b1;
                addr        = idx + ADDR_W'(1);
                state_n     = ST_CMP;
            end
            ST_CHECK: begin
                if (flag) begin
                    flag_n  = 1'b0;
                    idx_n   = '0;
                    state_n = ST_FETCH;
                end else begin
                    done    = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign busy = is_busy_state(state);

    // R4
    clean_pass_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && !flag) |=> (state == ST_IDLE));

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R6
    swap_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR_HI) |=> flag);
endmodule

// File: rtl/mem_bubble_sorter.sv
module mem_bubble_sorter
    import sort_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int DEPTH  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    output logic                     busy,
    output logic                     done,
    output logic [$clog2(DEPTH)-1:0] mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic                     mem_we,
    output logic                     mem_re
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int LAST   = DEPTH - 2;

    sort_ctl_t         ctl;
    logic              gt;
    logic [DATA_W-1:0] first_q, second_q;

    sort_ctrl #(.ADDR_W(ADDR_W), .LAST(LAST)) i_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .gt    (gt),
        .ctl   (ctl),
        .addr  (mem_addr),
        .busy  (busy),
        .done  (done)
    );

    sort_hold_pair #(.W(DATA_W)) i_hold (
        .clk      (clk),
        .rst      (rst),
        .bus_in   (mem_rdata),
        .ld_first (ctl.ld_first),
        .shift    (ctl.shift),
        .restore  (ctl.restore),
        .first_q  (first_q),
        .second_q (second_q)
    );

    sort_mag_cmp #(.W(DATA_W)) i_cmp (
        .a      (first_q),
        .b      (mem_rdata),
        .a_gt_b (gt)
    );

    assign mem_we    = ctl.wr;
    assign mem_re    = ctl.rd;
    assign mem_wdata = ctl.wsel_hi ? second_q : first_q;

    // R5
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R6
    swap_pair_order_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |->
            (mem_addr == $past(mem_addr) + 1'b1) && (mem_wdata > $past(mem_wdata)));

    // R7
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R7
    done_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!busy && !done));
endmodule

// File: tb/test_mem_bubble_sorter.sv
module test_mem_bubble_sorter;
    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       busy, done, mem_we, mem_re;
    logic [3:0] mem_addr, mem_wdata;
    logic [3:0] mem_rdata;

    always #4 clk = ~clk;

    mem_bubble_sorter i_mem_bubble_sorter (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_re(mem_re)
    );

    // Memory model: synchronous read, data one cycle after request (R10)
    logic [3:0] mem [N];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    typedef struct packed { logic [3:0] a; logic [3:0] d; } wr_t;
    wr_t exp_q[$];

    int checks = 0, failures = 0;
    int exp_cycles = 0, cyc = 0, wr_count = 0;
    bit finished = 0, prev_done = 0;
    logic [3:0] init_v [N];
    logic [3:0] ref_v [N];

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                wr_count++;
                if (exp_q.size() == 0) begin
                    chk(0, "R3/R6 unexpected write", int'(mem_addr), -1);
                end else begin
                    wr_t e;
                    e = exp_q.pop_front();
                    chk(mem_addr == e.a, "R6 write addr", int'(mem_addr), int'(e.a));
                    chk(mem_wdata == e.d, "R6 write data", int'(mem_wdata), int'(e.d));
                end
            end
            if (mem_we && mem_re) chk(0, "R5 we with re", 1, 0);
            if (prev_done) begin
                chk(!busy, "R7 busy after done", int'(busy), 0);
                chk(!done, "R7 done width", int'(done), 0);
            end
            if (busy) cyc++;
            if (done) begin
                chk(busy, "R7 busy with done", int'(busy), 1);
                chk(cyc == exp_cycles, "R9 busy cycles", cyc, exp_cycles);
                finished = 1;
            end
            prev_done = done;
        end
    end

    // Reference model from the requirements: expected writes and run length
    task automatic build_model();
        bit swapped;
        logic [3:0] t;
        exp_cycles = 0;
        for (int i = 0; i < N; i++) ref_v[i] = init_v[i];
        do begin
            swapped = 0;
            exp_cycles += 18;
            for (int i = 0; i < N - 1; i++) begin
                if (ref_v[i] > ref_v[i+1]) begin
                    exp_q.push_back('{a: 4'(i),   d: ref_v[i+1]});
                    exp_q.push_back('{a: 4'(i+1), d: ref_v[i]});
                    t = ref_v[i]; ref_v[i] = ref_v[i+1]; ref_v[i+1] = t;
                    exp_cycles += (i < N - 2) ? 3 : 2;
                    swapped = 1;
                end
            end
        end while (swapped);
    endtask

    task automatic run_sort(string name, bit poke);
        int guard;
        @(negedge clk);
        for (int i = 0; i < N; i++) mem[i] = init_v[i];
        build_model();
        cyc = 0; wr_count = 0; finished = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!finished && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (poke) start = (guard % 7 == 3);   // R8 pulses during busy
        end
        start = 1'b0;
        chk(finished, "R9 watchdog", guard, exp_cycles);
        repeat (2) @(negedge clk);
        for (int i = 0; i < N; i++)
            chk(mem[i] == ref_v[i], "R2 final word", int'(mem[i]), int'(ref_v[i]));
        chk(exp_q.size() == 0, "R6 missing writes", exp_q.size(), 0);
        exp_q.delete();
        $display("run %s: cycles=%0d writes=%0d", name, cyc, wr_count);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs during reset
        chk(!busy && !done, "R1 status in reset", int'(busy) + int'(done), 0);
        chk(!mem_we && !mem_re, "R1 mem ctl in reset", int'(mem_we) + int'(mem_re), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_we && !mem_re, "R1 after reset", int'(busy), 0);

        // R4 already ascending: one pass, no writes
        for (int i = 0; i < N; i++) init_v[i] = 4'(i);
        run_sort("ascending", 0);
        chk(wr_count == 0, "R3 sorted no write", wr_count, 0);
        chk(cyc == 18, "R4 single pass", cyc, 18);

        // R3 all equal: no writes
        for (int i = 0; i < N; i++) init_v[i] = 4'd9;
        run_sort("equal", 0);
        chk(wr_count == 0, "R3 equal no write", wr_count, 0);

        // Descending, worst case (R2, R6, R9)
        for (int i = 0; i < N; i++) init_v[i] = 4'(15 - i);
        run_sort("descending", 0);

        // Only last pair out of order (swap at pair 14)
        for (int i = 0; i < N; i++) init_v[i] = 4'(i);
        init_v[14] = 4'd15; init_v[15] = 4'd14;
        run_sort("last_pair", 0);
        chk(cyc == 38, "R9 last pair cost", cyc, 38);

        // Pseudo-random with duplicates, start poked while busy (R8)
        begin
            logic [7:0] lf = 8'hA5;
            for (int i = 0; i < N; i++) begin
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                init_v[i] = lf[3:0];
            end
        end
        run_sort("random_poke", 1);
        chk(!busy, "R8 idle after poked run", int'(busy), 0);

        // Pairs of duplicates reversed
        for (int i = 0; i < N; i++) init_v[i] = 4'(7 - i / 2);
        run_sort("dup_desc", 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule